// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the control and status front end for an external analog-to-digital converter. Software talks to it through a byte-wide special-function-register bus. It sees a control register that holds a start request, a repeat mode, a DMA mode, an interrupt flag and a channel code. It also sees a read-only status register that shows whether a conversion is in flight. The block turns those bits into a one-cycle start strobe and a latched channel code for the converter. It waits for the converter's done pulse and raises an interrupt request when a conversion or a DMA block ends.

In single-shot mode, one start request gives one conversion, and the request bit drops by itself afterwards. In repeat mode the converter is restarted after every completion for as long as the repeat bit stays set. In DMA mode the channel comes from an entry identifier presented by an external sequencer instead of the register. Each completion pulses an advance output, and the stop code ends the block with an interrupt. The interrupt flag is cleared by the processor's vector acknowledge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset both registers read 00h, and `adc_start`, `irq_req` and `dma_advance` are low.
- R2: The control register sits at address D8h with layout bit7 = interrupt flag, bit6 = DMA mode, bit5 = repeat mode, bit4 = single-shot start, bits3:0 = channel code, and it reads back what was written. The status register sits at F5h and reads {busy, 7'b0}. Writes to F5h have no effect, and any other address reads 00h.
- R3: One cycle after the single-shot bit becomes set with a launchable code, `adc_start` is high for exactly one cycle, `adc_chan` carries the code, and busy goes high. Busy stays high until the `adc_done` cycle; after that cycle busy is low and the single-shot bit reads 0.
- R4: While the repeat bit is set, a new start strobe follows one cycle after each completion. Once the bit is cleared, no further strobe follows.
- R5: Outside DMA mode every completed conversion sets the interrupt flag, and `irq_req` follows the flag.
- R6: A high `irq_ack` clears the flag on the next edge, and it wins over a software write of 1 or a hardware set in the same cycle.
- R7: `adc_chan` is captured at the start strobe. A register write during a conversion does not change it.
- R8: Only codes 0h to 8h (inputs 0 to 7, then temperature sensor) are launched. A reserved code (9h to Fh outside DMA mode, 9h to Eh in DMA mode) with a pending request gives no strobe and leaves busy low.
- R9: In DMA mode the channel comes from `dma_chan_id`. Each completion pulses `dma_advance` for one cycle and does not set the interrupt flag, and the next entry starts one cycle later.
- R10: In DMA mode, entry code Fh with a pending request gives no strobe. It sets the interrupt flag and clears both the single-shot and repeat bits.
- R11: `adc_done` while no conversion is in flight is ignored: busy, the flag and the strobe are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| irq_ack | input | 1 | Processor vector acknowledge, clears the flag |
| irq_req | output | 1 | Interrupt request (the flag) |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_chan | output | 4 | Channel code latched at the strobe |
| adc_done | input | 1 | Converter completion pulse |
| dma_chan_id | input | 4 | Channel identifier of the current DMA entry |
| dma_advance | output | 1 | One-cycle pulse asking for the next DMA entry |

## Verification
The hardest situation to reach is the end of a DMA block. It needs a run of entries already in progress, a completion that moves the sequence on, and the stop identifier presented in the single idle cycle before the next launch. The bench runs two real DMA entries with different channel identifiers and checks the advance pulse after each one. It then swaps the entry identifier to the stop code right after the second completion and checks that no strobe appears, that the flag rises and that both request bits read back cleared. The acknowledge race is reached by putting a software write of the flag and the acknowledge on the same edge.

// File: rtl/adc_seq_pkg.sv
// Shared types and constants for the ADC conversion sequencer.
// Assumes an 8-bit register bus and a 4-bit channel code.
package adc_seq_pkg;

    // Control register image, MSB first; the order matches the bus layout.
    typedef struct packed {
        logic       irq;
        logic       dma;
        logic       cconv;
        logic       sconv;
        logic [3:0] chan;
    } ctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_t;

    localparam logic [3:0] CH_TEMP = 4'h8;
    localparam logic [3:0] CH_STOP = 4'hF;

    // True for codes the converter accepts (inputs 0..7 and the temperature sensor).
    function automatic logic code_launchable(input logic [3:0] code);
        return code <= CH_TEMP;
    endfunction

endpackage

// File: rtl/adc_ctl_regs.sv
// Control/status register file for the ADC sequencer.
// Holds the control register, merges bus writes with hardware events
// (hardware after software, acknowledge last) and muxes read data.
// Assumes single-cycle writes; reads are combinational on bus_addr.
module adc_ctl_regs
    import adc_seq_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'hD8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hF5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              irq_ack,
    input  logic              ev_single_end,
    input  logic              ev_block_end,
    input  logic              busy,
    output ctl_t              ctl
);

    ctl_t ctl_nxt;

    // Next-state merge: software write, then hardware events, then acknowledge.
    always_comb begin
        ctl_nxt = ctl;
        if (bus_wr && bus_addr == CTL_ADDR) begin
            ctl_nxt = ctl_t'(bus_wdata);
        end
        if (ev_single_end) begin
            ctl_nxt.irq   = 1'b1;
            ctl_nxt.sconv = 1'b0;
        end
        if (ev_block_end) begin
            ctl_nxt.irq   = 1'b1;
            ctl_nxt.sconv = 1'b0;
            ctl_nxt.cconv = 1'b0;
        end
        if (irq_ack) begin
            ctl_nxt.irq = 1'b0;
        end
    end

    // Control register storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl <= '0;
        else        ctl <= ctl_nxt;
    end

    // Read data mux; the status register carries only the busy bit.
    always_comb begin
        if (bus_addr == CTL_ADDR)       bus_rdata = ctl;
        else if (bus_addr == STAT_ADDR) bus_rdata = {busy, 7'b0};
        else                            bus_rdata = 8'h00;
    end

    // R6: acknowledge always leaves the flag clear.
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !ctl.irq);

    // R5, R10: a hardware end event without acknowledge leaves the flag set.
    p_event_sets_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_single_end || ev_block_end) && !irq_ack) |=> ctl.irq);

    // R10: a block end removes both request bits.
    p_block_end_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_block_end |=> (!ctl.sconv && !ctl.cconv));

endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: decides when to launch, latches the channel,
// tracks the in-flight conversion and emits end-of-conversion events.
// Assumes adc_done is a one-cycle pulse; done outside a conversion is ignored.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [CHAN_W-1:0] dma_chan_id,
    input  logic              adc_done,
    output logic              adc_start,
    output logic [CHAN_W-1:0] adc_chan,
    output logic              busy,
    output logic              dma_advance,
    output logic              ev_single_end,
    output logic              ev_block_end
);

    seq_state_t        state;
    logic [CHAN_W-1:0] src_code;
    logic              req;
    logic              idle;
    logic              launch;
    logic              finish;

    // Launch and completion decode for the current cycle.
    always_comb begin
        src_code      = ctl.dma ? dma_chan_id : ctl.chan;
        req           = ctl.sconv || ctl.cconv;
        idle          = (state == ST_IDLE);
        launch        = idle && req && code_launchable(src_code);
        ev_block_end  = idle && req && ctl.dma && (src_code == CH_STOP);
        finish        = (state == ST_CONV) && adc_done;
        ev_single_end = finish && !ctl.dma;
        busy          = (state == ST_CONV);
    end

    // State, strobe, channel latch and DMA advance registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            adc_start   <= 1'b0;
            adc_chan    <= '0;
            dma_advance <= 1'b0;
        end else begin
            adc_start   <= launch;
            dma_advance <= finish && ctl.dma;
            if (launch) begin
                state    <= ST_CONV;
                adc_chan <= src_code;
            end else if (finish) begin
                state <= ST_IDLE;
            end
        end
    end

    // R3, R11: the start strobe lasts exactly one cycle.
    p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R3, R8: a strobe only ever carries a launchable code and marks busy.
    p_start_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (busy && adc_chan <= CH_TEMP));

    // R7: the channel holds for the rest of a conversion.
    p_chan_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !adc_start) |-> $stable(adc_chan));

    // R9: the advance pulse follows a conversion that was in flight.
    p_advance_after_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_advance |-> (!busy && $past(busy)));

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the ADC conversion control sequencer: register file plus sequencer.
// Assumes a single clock domain shared with the converter interface.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'hD8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hF5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic              adc_start,
    output logic [3:0]        adc_chan,
    input  logic              adc_done,
    input  logic [3:0]        dma_chan_id,
    output logic              dma_advance
);

    ctl_t ctl;
    logic busy;
    logic ev_single_end;
    logic ev_block_end;

    adc_ctl_regs #(
        .ADDR_W   (ADDR_W),
        .CTL_ADDR (CTL_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_ack      (irq_ack),
        .ev_single_end(ev_single_end),
        .ev_block_end (ev_block_end),
        .busy         (busy),
        .ctl          (ctl)
    );

    adc_conv_seq #(
        .CHAN_W(4)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl          (ctl),
        .dma_chan_id  (dma_chan_id),
        .adc_done     (adc_done),
        .adc_start    (adc_start),
        .adc_chan     (adc_chan),
        .busy         (busy),
        .dma_advance  (dma_advance),
        .ev_single_end(ev_single_end),
        .ev_block_end (ev_block_end)
    );

    // Interrupt request follows the flag.
    always_comb irq_req = ctl.irq;

    // R1: nothing is strobed or requested in the cycle after reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!adc_start && !irq_req && !dma_advance));

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq_ack;
    logic       irq_req;
    logic       adc_start;
    logic [3:0] adc_chan;
    logic       adc_done;
    logic [3:0] dma_chan_id;
    logic       dma_advance;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    localparam logic [7:0] A_CTL  = 8'hD8;
    localparam logic [7:0] A_STAT = 8'hF5;

    always #5 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_ack    (irq_ack),
        .irq_req    (irq_req),
        .adc_start  (adc_start),
        .adc_chan   (adc_chan),
        .adc_done   (adc_done),
        .dma_chan_id(dma_chan_id),
        .dma_advance(dma_advance)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic done_pulse();
        adc_done = 1'b1;
        tick();
        adc_done = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A_CTL, d);  chk("R1 ctl reset", d, 8'h00);
        rd(A_STAT, d); chk("R1 stat reset", d, 8'h00);
        chk("R1 start reset", {7'b0, adc_start}, 8'h00);
        chk("R1 irq reset", {7'b0, irq_req}, 8'h00);
        chk("R1 advance reset", {7'b0, dma_advance}, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(A_CTL, 8'h0C);
        rd(A_CTL, d);  chk("R2 ctl readback", d, 8'h0C);
        wr(A_STAT, 8'hFF);
        rd(A_STAT, d); chk("R2 stat write ignored", d, 8'h00);
        rd(A_CTL, d);  chk("R2 ctl untouched by stat write", d, 8'h0C);
        rd(8'h10, d);  chk("R2 unmapped reads zero", d, 8'h00);
        chk("R2 no start without request", {7'b0, adc_start}, 8'h00);
        wr(A_CTL, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] d;
        wr(A_CTL, 8'h13);
        chk("R3 no start on write edge", {7'b0, adc_start}, 8'h00);
        tick();
        chk("R3 strobe", {7'b0, adc_start}, 8'h01);
        chk("R3 channel", {4'b0, adc_chan}, 8'h03);
        rd(A_STAT, d); chk("R3 busy high", d, 8'h80);
        tick();
        chk("R3 strobe one cycle", {7'b0, adc_start}, 8'h00);
        rd(A_STAT, d); chk("R3 busy held", d, 8'h80);
        done_pulse();
        rd(A_STAT, d); chk("R3 busy cleared", d, 8'h00);
        rd(A_CTL, d);  chk("R3 R5 sconv cleared, flag set", d, 8'h83);
        chk("R5 irq_req", {7'b0, irq_req}, 8'h01);
        tick();
        chk("R3 no restart", {7'b0, adc_start}, 8'h00);
        ack();
        chk("R6 ack clears", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_ack_race();
        irq_ack = 1'b1;
        wr(A_CTL, 8'h80);
        irq_ack = 1'b0;
        chk("R6 ack beats write", {7'b0, irq_req}, 8'h00);
        wr(A_CTL, 8'h80);
        chk("R2 software sets flag", {7'b0, irq_req}, 8'h01);
        ack();
        chk("R6 ack clears software flag", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_cont();
        logic [7:0] d;
        wr(A_CTL, 8'h25);
        tick();
        chk("R4 first strobe", {7'b0, adc_start}, 8'h01);
        chk("R4 channel", {4'b0, adc_chan}, 8'h05);
        tick();
        done_pulse();
        chk("R4 no strobe in done cycle", {7'b0, adc_start}, 8'h00);
        chk("R5 flag on repeat completion", {7'b0, irq_req}, 8'h01);
        tick();
        chk("R4 rearm strobe", {7'b0, adc_start}, 8'h01);
        wr(A_CTL, 8'h05);
        done_pulse();
        tick();
        chk("R4 stops after clear", {7'b0, adc_start}, 8'h00);
        rd(A_STAT, d); chk("R4 idle after clear", d, 8'h00);
        ack();
        wr(A_CTL, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        wr(A_CTL, 8'h12);
        tick();
        chk("R7 launched ch2", {4'b0, adc_chan}, 8'h02);
        wr(A_CTL, 8'h17);
        chk("R7 chan held after write", {4'b0, adc_chan}, 8'h02);
        chk("R7 no second strobe", {7'b0, adc_start}, 8'h00);
        tick();
        chk("R7 chan still held", {4'b0, adc_chan}, 8'h02);
        done_pulse();
        rd(A_CTL, d); chk("R7 ctl after done", d, 8'h87);
        tick();
        chk("R7 no start after done", {7'b0, adc_start}, 8'h00);
        ack();
        wr(A_CTL, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        logic seen;
        seen = 1'b0;
        wr(A_CTL, 8'h1A);
        for (int i = 0; i < 3; i++) begin
            tick();
            seen = seen | adc_start;
        end
        chk("R8 reserved 0xA no strobe", {7'b0, seen}, 8'h00);
        rd(A_STAT, d); chk("R8 reserved busy low", d, 8'h00);
        seen = 1'b0;
        wr(A_CTL, 8'h1F);
        for (int i = 0; i < 3; i++) begin
            tick();
            seen = seen | adc_start;
        end
        chk("R8 code F outside DMA no strobe", {7'b0, seen}, 8'h00);
        chk("R8 code F outside DMA no flag", {7'b0, irq_req}, 8'h00);
        wr(A_CTL, 8'h00);
    endtask

    task automatic t_idle_done();
        logic [7:0] d;
        done_pulse();
        rd(A_STAT, d); chk("R11 idle done busy", d, 8'h00);
        chk("R11 idle done flag", {7'b0, irq_req}, 8'h00);
        chk("R11 idle done strobe", {7'b0, adc_start}, 8'h00);
    endtask

    task automatic t_dma();
        logic [7:0] d;
        dma_chan_id = 4'h6;
        wr(A_CTL, 8'h50);
        tick();
        chk("R9 entry channel", {4'b0, adc_chan}, 8'h06);
        chk("R9 entry strobe", {7'b0, adc_start}, 8'h01);
        tick();
        done_pulse();
        chk("R9 advance pulse", {7'b0, dma_advance}, 8'h01);
        chk("R9 no flag per entry", {7'b0, irq_req}, 8'h00);
        dma_chan_id = 4'h2;
        tick();
        chk("R9 next entry strobe", {7'b0, adc_start}, 8'h01);
        chk("R9 next entry channel", {4'b0, adc_chan}, 8'h02);
        chk("R9 advance one cycle", {7'b0, dma_advance}, 8'h00);
        done_pulse();
        chk("R9 second advance", {7'b0, dma_advance}, 8'h01);
        dma_chan_id = 4'hF;
        tick();
        chk("R10 stop no strobe", {7'b0, adc_start}, 8'h00);
        chk("R10 stop sets flag", {7'b0, irq_req}, 8'h01);
        rd(A_CTL, d); chk("R10 requests cleared", d, 8'hC0);
        tick();
        chk("R10 stays stopped", {7'b0, adc_start}, 8'h00);
        ack();
        wr(A_CTL, 8'h00);
        dma_chan_id = 4'h0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_wdata = 8'h00;
        irq_ack = 1'b0; adc_done = 1'b0; dma_chan_id = 4'h0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regmap();
        t_single();
        t_ack_race();
        t_cont();
        t_latch();
        t_reserved();
        t_idle_done();
        t_dma();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule